// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Aggregator

This block combines 32 interrupt sources into one active-high request line for a host bridge. Sixteen of the sources are FIFO status flags, four for each of four serial channels. The other sixteen are level-type request lines coming from the serial controllers. Every source has its own enable bit, its own trigger-mode bit (edge or level) and its own polarity bit (high/rising or low/falling). All of these bits sit in one register set.

In edge mode a source reports the programmed transition. It does this by comparing the input against the value it held on the previous clock, and it latches a sticky status bit. Software removes that bit by writing 1 to it. In level mode the status bit is not stored. It shows the live input, qualified by polarity, so a clear write does nothing while the input stays active. The request output is the registered OR over all sources of status AND enable.

Software reaches the registers through a plain address, write-data and write-enable port. Reads are combinational. Inputs are assumed to be synchronous to the block clock.

Top module: `fic_top`

## Requirements
- R1: After reset the enable register reads 0, the trigger-mode register reads 0 (all sources level), the polarity register reads all ones (high/rising), the status register reads 0 while all inputs are low, and `irq_o` is 0.
- R2: Register selection by `reg_addr`: 0 = enable, 1 = status, 2 = trigger mode (bit value 1 = edge, 0 = level), 3 = polarity (bit value 1 = high/rising, 0 = low/falling). Bit n of each register belongs to source n. A write to address 0, 2 or 3 loads `reg_wdata` at the clock edge, and the value then reads back unchanged.
- R3: An edge-mode source with polarity 1 sets its status bit at the first clock edge where the input is sampled 1 after being sampled 0. The bit stays set after the input returns low.
- R4: An edge-mode source with polarity 0 sets its status bit at the first clock edge where the input is sampled 0 after being sampled 1. A rising transition on that source does not set the bit.
- R5: Writing to address 1 clears each edge-mode status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged.
- R6: When a new edge event and a clear of the same bit arrive in the same clock cycle, the status bit remains set.
- R7: A level-mode status bit reads the live input (polarity 1) or its inverse (polarity 0) in the same cycle, with no register delay. Writing 1 to it at address 1 does not clear it while the input stays active.
- R8: A level-mode status bit shows an active input even when that source's enable bit is 0.
- R9: `irq_o` is the OR of (status AND enable) sampled at the previous clock edge. It rises one cycle after an enabled status bit becomes 1, falls one cycle after the last enabled status bit becomes 0, and ignores status bits whose enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data, one bit per source |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| src_i | input | 32 | Sources: bits 4c..4c+3 are tx-empty, tx-full, rx-empty, rx-full of channel c; bits 16..31 are controller lines |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The hardest case to reach from the ports is a clear write landing in exactly the cycle where a fresh edge arrives on the same source. Reaching it needs a bit that is already latched, its input held inactive for one cycle, and then the input transition and the status write driven together at one falling clock edge. The bench sets up that cycle directly in a dedicated task and reads the status back afterwards. A second delicate point is the one-cycle lag of the request line behind status, in both directions. Each scenario samples `irq_o` at the falling edge just before and just after the expected change.

// File: rtl/fic_pkg.sv
package fic_pkg;
    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_POL    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/fic_cfg.sv
module fic_cfg
    import fic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      addr,
    input  logic [NSRC-1:0] wdata,
    input  logic            we,
    input  logic [NSRC-1:0] stat_view,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] mode_q,
    output logic [NSRC-1:0] pol_q,
    output logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '1;
        end else if (we) begin
            unique case (sel)
                SEL_ENABLE: en_q   <= wdata;
                SEL_STATUS: ;
                SEL_MODE:   mode_q <= wdata;
                SEL_POL:    pol_q  <= wdata;
            endcase
        end
    end

    assign clr = (we && sel == SEL_STATUS) ? wdata : '0;

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rdata = en_q;
            SEL_STATUS: rdata = stat_view;
            SEL_MODE:   rdata = mode_q;
            SEL_POL:    rdata = pol_q;
        endcase
    end

    // R2
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ENABLE) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/fic_slice.sv
module fic_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic edge_mode,
    input  logic pol,
    input  logic clr,
    output logic stat
);
    logic src_q;
    logic held_q;
    logic evt;
    logic lvl;
    logic held_d;

    always_comb begin
        evt    = edge_mode & (pol ? (src & ~src_q) : (~src & src_q));
        lvl    = pol ? src : ~src;
        held_d = edge_mode ? ((held_q & ~clr) | evt) : 1'b0;
        stat   = edge_mode ? held_q : lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            src_q  <= src;
            held_q <= held_d;
        end
    end

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && held_q && !clr) |=> held_q);

    // R6
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr && evt) |=> held_q);
endmodule

// File: rtl/fic_irq.sv
module fic_irq #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] stat,
    input  logic [NSRC-1:0] en,
    output logic            irq
);
    logic any_req;
    assign any_req = |(stat & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_req;
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> irq);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !irq);
endmodule

// File: rtl/fic_top.sv
module fic_top #(
    parameter int N_CHAN    = 4,
    parameter int CH_FLAGS  = 4,
    parameter int N_LINES   = 16,
    localparam int NSRC     = N_CHAN * CH_FLAGS + N_LINES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    input  logic            reg_we,
    output logic [NSRC-1:0] reg_rdata,
    input  logic [NSRC-1:0] src_i,
    output logic            irq_o
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] mode_q;
    logic [NSRC-1:0] pol_q;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] stat;

    fic_cfg #(.NSRC(NSRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .stat_view (stat),
        .en_q      (en_q),
        .mode_q    (mode_q),
        .pol_q     (pol_q),
        .clr       (clr),
        .rdata     (reg_rdata)
    );

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        fic_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_i[n]),
            .edge_mode (mode_q[n]),
            .pol       (pol_q[n]),
            .clr       (clr[n]),
            .stat      (stat[n])
        );
    end

    fic_irq #(.NSRC(NSRC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat),
        .en    (en_q),
        .irq   (irq_o)
    );
endmodule

// File: tb/fic_top_test.sv
`timescale 1ns/1ps
module fic_top_test;
    localparam int W = 32;
    localparam logic [1:0] A_EN = 2'd0, A_ST = 2'd1, A_MODE = 2'd2, A_POL = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic         reg_we = 1'b0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] src_i = '0;
    logic         irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fic_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .src_i(src_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        rd(A_EN, d);   chk("R1 enable", d, '0);
        rd(A_MODE, d); chk("R1 mode", d, '0);
        rd(A_POL, d);  chk("R1 polarity", d, '1);
        rd(A_ST, d);   chk("R1 status", d, '0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_readback();
        logic [W-1:0] d;
        wr(A_MODE, 32'hA5C3_0F18); rd(A_MODE, d); chk("R2 mode readback", d, 32'hA5C3_0F18);
        wr(A_POL, 32'h5A3C_F0E7);  rd(A_POL, d);  chk("R2 pol readback", d, 32'h5A3C_F0E7);
        wr(A_EN, 32'h0000_8001);   rd(A_EN, d);   chk("R2 enable readback", d, 32'h0000_8001);
        wr(A_MODE, '0); wr(A_POL, '1); wr(A_EN, '0);
    endtask

    task automatic t_rise();
        logic [W-1:0] d;
        wr(A_MODE, 32'h0000_0024);
        wr(A_EN, 32'h0000_0004);
        @(negedge clk); src_i[2] = 1'b1;
        @(negedge clk);
        rd(A_ST, d); chk("R3 rising sets", d & 32'h4, 32'h4);
        chk("R9 irq lags status", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R9 irq rises", {31'd0, irq_o}, 32'd1);
        src_i[2] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(A_ST, d); chk("R3 sticky after low", d & 32'h4, 32'h4);
    endtask

    task automatic t_clear();
        logic [W-1:0] d;
        wr(A_ST, 32'h0);
        rd(A_ST, d); chk("R5 zero write keeps", d & 32'h4, 32'h4);
        wr(A_ST, 32'h4);
        rd(A_ST, d); chk("R5 clear", d & 32'h4, 32'h0);
        chk("R9 irq still high", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        chk("R9 irq falls", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_fall();
        logic [W-1:0] d;
        wr(A_POL, ~32'h0000_0020);
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_ST, d); chk("R4 rise ignored", d & 32'h20, 32'h0);
        src_i[5] = 1'b0;
        @(negedge clk);
        rd(A_ST, d); chk("R4 falling sets", d & 32'h20, 32'h20);
        chk("R9 disabled bit no irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_race();
        logic [W-1:0] d;
        @(negedge clk); src_i[2] = 1'b1;
        @(negedge clk); src_i[2] = 1'b0;
        @(negedge clk);
        rd(A_ST, d); chk("R6 setup", d & 32'h4, 32'h4);
        @(negedge clk);
        src_i[2] = 1'b1; reg_addr = A_ST; reg_wdata = 32'h4; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        rd(A_ST, d); chk("R6 edge wins over clear", d & 32'h4, 32'h4);
        wr(A_ST, 32'h4);
        rd(A_ST, d); chk("R5 clear after race", d & 32'h4, 32'h0);
        src_i[2] = 1'b0;
    endtask

    task automatic t_level();
        logic [W-1:0] d;
        wr(A_EN, '0);
        @(negedge clk);
        src_i[20] = 1'b1;
        rd(A_ST, d); chk("R7 R8 level live while disabled", d & 32'h0010_0000, 32'h0010_0000);
        @(negedge clk);
        chk("R9 disabled level no irq", {31'd0, irq_o}, 32'd0);
        wr(A_ST, 32'h0010_0000);
        rd(A_ST, d); chk("R7 clear no effect", d & 32'h0010_0000, 32'h0010_0000);
        wr(A_EN, 32'h0010_0000);
        chk("R9 irq before enable seen", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R9 level irq", {31'd0, irq_o}, 32'd1);
        src_i[20] = 1'b0;
        rd(A_ST, d); chk("R7 level drops", d & 32'h0010_0000, 32'h0);
        chk("R9 irq holds one cycle", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        chk("R9 level irq falls", {31'd0, irq_o}, 32'd0);
        wr(A_POL, ~32'h0020_0020);
        rd(A_ST, d); chk("R7 low polarity level", d & 32'h0020_0000, 32'h0020_0000);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R9 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_rise();
        t_clear();
        t_fall();
        t_race();
        t_level();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule